// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Sequencer

This block is the host-side engine for single programmed-I/O register and data transfers on a parallel ATA-style bus. A request gives a read/write flag, a five-bit device address, write data and a transfer mode. The block then runs one complete bus cycle. It has an address setup phase, an active-strobe phase, an optional wait extension and a recovery phase, and it signals the end with a one-cycle done pulse. Read data is returned with that pulse.

Each phase length comes from a per-mode table of clock counts. In the two fast modes (3 and 4), the device's ready line is sampled once, at a fixed point inside the strobe. If the line is low at that point, the strobe is held until the device becomes ready or a timeout expires. The fast modes also enforce a programmable floor on the total cycle length. A narrow 8-bit data mode uses only the low byte of the data bus. The DMA acknowledge line is held inactive at all times.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset the block is idle: both strobes, both chip selects and `dmackN` are high, `ddOe` and `done` are low, and `curMode` reads 0.
- R2: Address encoding is as follows. `reqAddr[4]` asserts (drives low) `cs1N`, `reqAddr[3]` asserts `cs0N`, and `reqAddr[2:0]` appears on `daOut`. The address is driven unchanged from the first setup cycle to the last recovery cycle, and both selects are released when idle.
- R3: Without extension, a cycle spends S setup cycles with the strobes high, then A cycles with the strobe low, then R recovery cycles, where S, A and R are the selected mode's counts and a count of 0 acts as 1. The read strobe `diorN` is used for reads and `diowN` for writes.
- R4: In modes 3 and 4, `iordy` passes through a two-flop synchronizer and is sampled once, in strobe cycle number `cfgSamplePt` (counted from 0). If it is seen low there, the strobe stays low until it is seen high, after which the remaining strobe cycles from that cycle onward are run.
- R5: An `iordy` low pulse that has ended, after synchronization, before the sample point adds no wait.
- R6: In modes 0 to 2, `iordy` is ignored and the strobe lasts exactly A cycles.
- R7: In modes 3 and 4, the busy time of a cycle is at least `cfgMinCycle` clocks, with recovery lengthened as needed. In lower modes this floor has no effect.
- R8: Read data is captured from `ddIn` on the edge that ends the strobe. In 8-bit mode (`cfgByteMode`=1) `rdData[15:8]` is 0 and `rdData[7:0]` is `ddIn[7:0]`.
- R9: For writes, `ddOe` is high for every strobe cycle and for the first H recovery cycles (H the mode's hold count), and low during setup. `ddOut` carries the write data, with the upper byte zero in 8-bit mode. For reads, `ddOe` stays low.
- R10: If a wait lasts `cfgTimeout` cycles (0 acts as 1), the strobe ends, recovery runs and `err` rises together with `done`. If ready is seen on the same edge the timeout would fire, ready wins and `err` stays low.
- R11: `dmackN` stays high, and `diorN` and `diowN` are never low together.
- R12: `done` is a one-cycle pulse in the clock after the last recovery cycle, with `busy` low. A request presented while busy is ignored. A mode above 4 is treated as 4 and is shown on `curMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a cycle (taken only when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 5 | {select1, select0, register address[2:0]} |
| reqWdata | input | 16 | Write data |
| reqMode | input | 3 | Transfer mode 0..4 |
| cfgByteMode | input | 1 | 8-bit data mode |
| cfgSetup | input | 40 | Setup count per mode, 8 bits each, mode 0 lowest |
| cfgActive | input | 40 | Strobe count per mode |
| cfgRecov | input | 40 | Recovery count per mode |
| cfgHold | input | 40 | Write hold count per mode |
| cfgSamplePt | input | 8 | Strobe cycle index where ready is sampled |
| cfgMinCycle | input | 16 | Minimum cycle length in fast modes |
| cfgTimeout | input | 16 | Wait limit in clocks |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Cycle ended by timeout (with done) |
| rdData | output | 16 | Captured read data |
| curMode | output | 3 | Mode of the current or last cycle |
| cs0N | output | 1 | Chip select 0, active low |
| cs1N | output | 1 | Chip select 1, active low |
| daOut | output | 3 | Register address |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| dmackN | output | 1 | DMA acknowledge, held high |
| ddOut | output | 16 | Data bus out |
| ddOe | output | 1 | Data bus drive enable |
| ddIn | input | 16 | Data bus in |
| iordy | input | 1 | Device ready, low requests a wait |

## Verification
The wait exit on a returning ready and the wait timeout can fall on the same clock edge. The bench provokes this by raising `iordy` at a strobe-cycle count chosen so that its synchronized value arrives exactly on the timeout edge. It then judges the outcome by the strobe length and by `err` staying low at `done`. A second case raises ready one cycle later and expects the timeout to win. A second overlap is between the minimum-cycle floor and normal recovery completion. Random cycles in fast modes, with floors both above and below S+A+R, check that the total busy time equals the larger of the two.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_RECOV
  } seqState_e;

  // control strobes handed from sequencer to datapath
  typedef struct packed {
    logic accept;     // latch the request this edge
    logic strobeOn;   // read or write strobe asserted
    logic capture;    // sample read data this edge
    logic driveOn;    // data bus drive window (write only)
    logic finish;     // last recovery cycle ends this edge
    logic finishErr;  // the finishing cycle was cut by timeout
  } seqCtl_t;

endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel #(
  parameter int NUM_MODES = 5,
  parameter int CNT_W     = 8,
  localparam int MODE_W   = $clog2(NUM_MODES)
) (
  input  logic [MODE_W-1:0]          mode,
  input  logic [NUM_MODES*CNT_W-1:0] cfgSetup,
  input  logic [NUM_MODES*CNT_W-1:0] cfgActive,
  input  logic [NUM_MODES*CNT_W-1:0] cfgRecov,
  input  logic [NUM_MODES*CNT_W-1:0] cfgHold,
  output logic [CNT_W-1:0]           setupLen,
  output logic [CNT_W-1:0]           activeLen,
  output logic [CNT_W-1:0]           recovLen,
  output logic [CNT_W-1:0]           holdLen
);

  logic [CNT_W-1:0] setupTab  [NUM_MODES];
  logic [CNT_W-1:0] activeTab [NUM_MODES];
  logic [CNT_W-1:0] recovTab  [NUM_MODES];
  logic [CNT_W-1:0] holdTab   [NUM_MODES];

  // unpack the flat tables; a zero phase count is raised to one clock
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_unpack
    logic [CNT_W-1:0] rawSetup, rawActive, rawRecov;
    assign rawSetup     = cfgSetup [m*CNT_W +: CNT_W];
    assign rawActive    = cfgActive[m*CNT_W +: CNT_W];
    assign rawRecov     = cfgRecov [m*CNT_W +: CNT_W];
    assign setupTab[m]  = (rawSetup  == '0) ? CNT_W'(1) : rawSetup;
    assign activeTab[m] = (rawActive == '0) ? CNT_W'(1) : rawActive;
    assign recovTab[m]  = (rawRecov  == '0) ? CNT_W'(1) : rawRecov;
    assign holdTab[m]   = cfgHold[m*CNT_W +: CNT_W];
  end

  logic [MODE_W-1:0] modeIdx;
  assign modeIdx = (32'(mode) >= NUM_MODES) ? MODE_W'(NUM_MODES - 1) : mode;

  assign setupLen  = setupTab[modeIdx];
  assign activeLen = activeTab[modeIdx];
  assign recovLen  = recovTab[modeIdx];
  assign holdLen   = holdTab[modeIdx];

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TOT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             rdySync,
  input  logic             modeFast,
  input  logic [CNT_W-1:0] setupLen,
  input  logic [CNT_W-1:0] activeLen,
  input  logic [CNT_W-1:0] recovLen,
  input  logic [CNT_W-1:0] holdLen,
  input  logic [CNT_W-1:0] samplePt,
  input  logic [TOT_W-1:0] minCycle,
  input  logic [TOT_W-1:0] timeout,
  output seqCtl_t          ctl,
  output logic             busy
);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseNext;
  logic [TOT_W-1:0] waitCnt, waitNext;
  logic [TOT_W-1:0] totalCnt;
  logic             sampled, sampledNext;
  logic             errFlag, errNext;

  logic [TOT_W-1:0] waitLimit;
  logic [TOT_W:0]   totalPlusOne;
  logic             setupEnd, activeEnd, recovEnd, floorMet, readyLow;

  assign waitLimit    = (timeout == '0) ? TOT_W'(1) : timeout;
  assign totalPlusOne = {1'b0, totalCnt} + 1'b1;
  assign setupEnd     = (phaseCnt >= setupLen  - 1'b1);
  assign activeEnd    = (phaseCnt >= activeLen - 1'b1);
  assign recovEnd     = (phaseCnt >= recovLen  - 1'b1);
  assign floorMet     = !modeFast || (totalPlusOne >= {1'b0, minCycle});
  assign readyLow     = modeFast && !sampled && (phaseCnt == samplePt) && !rdySync;

  always_comb begin
    stateNext   = state;
    phaseNext   = phaseCnt;
    waitNext    = waitCnt;
    sampledNext = sampled;
    errNext     = errFlag;
    ctl         = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          stateNext  = ST_SETUP;
          phaseNext  = '0;
          errNext    = 1'b0;
        end
      end
      ST_SETUP: begin
        if (setupEnd) begin
          stateNext   = ST_ACTIVE;
          phaseNext   = '0;
          sampledNext = 1'b0;
        end else begin
          phaseNext = phaseCnt + 1'b1;
        end
      end
      ST_ACTIVE: begin
        ctl.strobeOn = 1'b1;
        if (readyLow) begin
          stateNext = ST_WAIT;
          waitNext  = '0;
        end else if (activeEnd) begin
          ctl.capture = 1'b1;
          stateNext   = ST_RECOV;
          phaseNext   = '0;
        end else begin
          phaseNext = phaseCnt + 1'b1;
        end
      end
      ST_WAIT: begin
        ctl.strobeOn = 1'b1;
        if (rdySync) begin
          stateNext   = ST_ACTIVE;
          sampledNext = 1'b1;
        end else if (waitCnt >= waitLimit - 1'b1) begin
          stateNext = ST_RECOV;
          phaseNext = '0;
          errNext   = 1'b1;
        end else begin
          waitNext = waitCnt + 1'b1;
        end
      end
      ST_RECOV: begin
        if (recovEnd && floorMet) begin
          ctl.finish    = 1'b1;
          ctl.finishErr = errFlag;
          stateNext     = ST_IDLE;
        end else if (phaseCnt != '1) begin
          phaseNext = phaseCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    ctl.driveOn = ctl.strobeOn || ((state == ST_RECOV) && (phaseCnt < holdLen));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      waitCnt  <= '0;
      totalCnt <= '0;
      sampled  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseNext;
      waitCnt  <= waitNext;
      sampled  <= sampledNext;
      errFlag  <= errNext;
      if (stateNext == ST_IDLE || state == ST_IDLE) begin
        totalCnt <= '0;
      end else if (totalCnt != '1) begin
        totalCnt <= totalCnt + 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_MODES = 5,
  parameter int FAST_MODE = 3,
  localparam int MODE_W   = $clog2(NUM_MODES),
  localparam int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              busy,
  input  logic              reqWrite,
  input  logic [4:0]        reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              cfgByteMode,
  input  logic [DATA_W-1:0] ddIn,
  input  logic              iordy,
  output logic              rdySync,
  output logic              modeFast,
  output logic [MODE_W-1:0] curMode,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdData,
  output logic              cs0N,
  output logic              cs1N,
  output logic [2:0]        daOut,
  output logic              diorN,
  output logic              diowN,
  output logic [DATA_W-1:0] ddOut,
  output logic              ddOe
);

  function automatic logic [DATA_W-1:0] narrowData(input logic narrow,
                                                   input logic [DATA_W-1:0] value);
    narrowData = narrow ? {{(DATA_W-BYTE_W){1'b0}}, value[BYTE_W-1:0]} : value;
  endfunction

  logic              writeLat, byteLat;
  logic [4:0]        addrLat;
  logic [DATA_W-1:0] wdataLat;
  logic              rdyMeta;
  logic [MODE_W-1:0] modeClamped;

  assign modeClamped = (32'(reqMode) >= NUM_MODES) ? MODE_W'(NUM_MODES - 1) : reqMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeLat <= 1'b0;
      byteLat  <= 1'b0;
      addrLat  <= '0;
      wdataLat <= '0;
      curMode  <= '0;
    end else if (ctl.accept) begin
      writeLat <= reqWrite;
      byteLat  <= cfgByteMode;
      addrLat  <= reqAddr;
      wdataLat <= narrowData(cfgByteMode, reqWdata);
      curMode  <= modeClamped;
    end
  end

  // two-stage synchronizer for the device ready line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyMeta <= 1'b1;
      rdySync <= 1'b1;
    end else begin
      rdyMeta <= iordy;
      rdySync <= rdyMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (ctl.capture && !writeLat) rdData <= narrowData(byteLat, ddIn);
      done <= ctl.finish;
      err  <= ctl.finish && ctl.finishErr;
    end
  end

  assign modeFast = (32'(curMode) >= FAST_MODE);
  assign cs1N     = !(busy && addrLat[4]);
  assign cs0N     = !(busy && addrLat[3]);
  assign daOut    = busy ? addrLat[2:0] : 3'b000;
  assign diorN    = !(ctl.strobeOn && !writeLat);
  assign diowN    = !(ctl.strobeOn && writeLat);
  assign ddOut    = wdataLat;
  assign ddOe     = ctl.driveOn && writeLat;

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_pkg::*;
#(
  parameter int NUM_MODES = 5,
  parameter int CNT_W     = 8,
  parameter int TOT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int FAST_MODE = 3,
  localparam int MODE_W   = $clog2(NUM_MODES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [4:0]                 reqAddr,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic [MODE_W-1:0]          reqMode,
  input  logic                       cfgByteMode,
  input  logic [NUM_MODES*CNT_W-1:0] cfgSetup,
  input  logic [NUM_MODES*CNT_W-1:0] cfgActive,
  input  logic [NUM_MODES*CNT_W-1:0] cfgRecov,
  input  logic [NUM_MODES*CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0]           cfgSamplePt,
  input  logic [TOT_W-1:0]           cfgMinCycle,
  input  logic [TOT_W-1:0]           cfgTimeout,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic [DATA_W-1:0]          rdData,
  output logic [MODE_W-1:0]          curMode,
  output logic                       cs0N,
  output logic                       cs1N,
  output logic [2:0]                 daOut,
  output logic                       diorN,
  output logic                       diowN,
  output logic                       dmackN,
  output logic [DATA_W-1:0]          ddOut,
  output logic                       ddOe,
  input  logic [DATA_W-1:0]          ddIn,
  input  logic                       iordy
);

  seqCtl_t          ctl;
  logic             rdySync, modeFast;
  logic [CNT_W-1:0] setupLen, activeLen, recovLen, holdLen;

  pio_timing_sel #(.NUM_MODES(NUM_MODES), .CNT_W(CNT_W)) u_timing (
    .mode(curMode), .cfgSetup(cfgSetup), .cfgActive(cfgActive),
    .cfgRecov(cfgRecov), .cfgHold(cfgHold),
    .setupLen(setupLen), .activeLen(activeLen),
    .recovLen(recovLen), .holdLen(holdLen)
  );

  pio_ctrl #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rdySync(rdySync),
    .modeFast(modeFast), .setupLen(setupLen), .activeLen(activeLen),
    .recovLen(recovLen), .holdLen(holdLen), .samplePt(cfgSamplePt),
    .minCycle(cfgMinCycle), .timeout(cfgTimeout), .ctl(ctl), .busy(busy)
  );

  pio_datapath #(.DATA_W(DATA_W), .NUM_MODES(NUM_MODES), .FAST_MODE(FAST_MODE)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMode(reqMode),
    .cfgByteMode(cfgByteMode), .ddIn(ddIn), .iordy(iordy),
    .rdySync(rdySync), .modeFast(modeFast), .curMode(curMode),
    .done(done), .err(err), .rdData(rdData), .cs0N(cs0N), .cs1N(cs1N),
    .daOut(daOut), .diorN(diorN), .diowN(diowN), .ddOut(ddOut), .ddOe(ddOe)
  );

  // no DMA on this engine: acknowledge stays inactive
  assign dmackN = 1'b1;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       diorN,
  input logic       diowN,
  input logic       ddOe,
  input logic       cs0N,
  input logic       cs1N,
  input logic [2:0] daOut
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!diorN || !diowN) |-> $stable({cs1N, cs0N, daOut}));

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (cs0N && cs1N));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R9
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !diorN |-> !ddOe);

  // R3
  strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!diorN || !diowN) |-> busy);

endmodule

bind pio_cycle_seq pio_cycle_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .diorN(diorN), .diowN(diowN), .ddOe(ddOe),
  .cs0N(cs0N), .cs1N(cs1N), .daOut(daOut)
);

// File: tb/pio_cycle_seq_bench.sv
module pio_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, cfgByteMode = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0, ddIn = '0;
  logic [2:0]  reqMode = '0;
  logic [39:0] cfgSetup, cfgActive, cfgRecov, cfgHold;
  logic [7:0]  cfgSamplePt = 8'd2;
  logic [15:0] cfgMinCycle = '0, cfgTimeout = 16'd100;
  logic        iordy = 1'b1;
  logic        busy, done, err, cs0N, cs1N, diorN, diowN, dmackN, ddOe;
  logic [15:0] rdData, ddOut;
  logic [2:0]  curMode, daOut;

  logic [7:0] su [5];
  logic [7:0] ac [5];
  logic [7:0] rc [5];
  logic [7:0] hd [5];

  always_comb begin
    for (int m = 0; m < 5; m++) begin
      cfgSetup [m*8 +: 8] = su[m];
      cfgActive[m*8 +: 8] = ac[m];
      cfgRecov [m*8 +: 8] = rc[m];
      cfgHold  [m*8 +: 8] = hd[m];
    end
  end

  pio_cycle_seq u_pio_cycle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMode(reqMode),
    .cfgByteMode(cfgByteMode), .cfgSetup(cfgSetup), .cfgActive(cfgActive),
    .cfgRecov(cfgRecov), .cfgHold(cfgHold), .cfgSamplePt(cfgSamplePt),
    .cfgMinCycle(cfgMinCycle), .cfgTimeout(cfgTimeout), .busy(busy),
    .done(done), .err(err), .rdData(rdData), .curMode(curMode),
    .cs0N(cs0N), .cs1N(cs1N), .daOut(daOut), .diorN(diorN), .diowN(diowN),
    .dmackN(dmackN), .ddOut(ddOut), .ddOe(ddOe), .ddIn(ddIn), .iordy(iordy)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int c1(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  function automatic logic [15:0] narrow(input bit b, input logic [15:0] v);
    return b ? {8'h00, v[7:0]} : v;
  endfunction

  // measurements of the last cycle
  int mSetup, mLow, mRec, mTot, mOe, mDones, mAddrBad, mDataBad, mSetupOe;
  bit mErr;
  logic [15:0] mRd;

  task automatic runCycle(input bit wr, input logic [4:0] a, input logic [15:0] wd,
                          input logic [2:0] mode, input int raiseAt,
                          input int releaseAt, input bit poke);
    logic [15:0] expWd;
    int guard;
    expWd = narrow(cfgByteMode, wd);
    mSetup = 0; mLow = 0; mRec = 0; mTot = 0; mOe = 0; mDones = 0;
    mAddrBad = 0; mDataBad = 0; mSetupOe = 0; mErr = 0; guard = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqMode = mode;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && guard < 5000) begin
      guard++;
      if (busy) begin
        mTot++;
        if (cs1N !== ~a[4] || cs0N !== ~a[3] || daOut !== a[2:0]) mAddrBad++;
        if (!diorN || !diowN) begin
          mLow++;
          if (wr && (diowN || !ddOe || ddOut !== expWd)) mDataBad++;
          if (!wr && (diorN || ddOe)) mDataBad++;
        end else if (mLow == 0) begin
          mSetup++;
          if (ddOe) mSetupOe++;
        end else begin
          mRec++;
          if (ddOe) mOe++;
        end
      end
      if (raiseAt > 0 && mLow == raiseAt) iordy = 1'b1;
      if (releaseAt > 0 && mSetup == releaseAt) iordy = 1'b1;
      if (poke && mSetup == 1 && mLow == 0) begin
        reqValid = 1'b1; reqAddr = ~a; reqWrite = ~wr;
      end else begin
        reqValid = 1'b0; reqAddr = a; reqWrite = wr;
      end
      @(negedge clk);
    end
    mErr = err; mRd = rdData;
    while (done) begin mDones++; @(negedge clk); end
    repeat (3) begin
      if (done) mDones++;
      @(negedge clk);
    end
  endtask

  task automatic setMode(input int m, input int s, input int a, input int r, input int h);
    su[m] = 8'(s); ac[m] = 8'(a); rc[m] = 8'(r); hd[m] = 8'(h);
  endtask

  task automatic iordyLow();
    iordy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic iordyHigh();
    iordy = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed, expTot, expRec, expLow;
    logic [15:0] din;
    seed = $urandom(32'h5A17);
    for (int m = 0; m < 5; m++) setMode(m, 2, 3, 2, 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 0 && diorN === 1 && diowN === 1 && cs0N === 1 && cs1N === 1
          && ddOe === 0 && done === 0 && dmackN === 1 && curMode === 0,
          "R1", "reset outputs", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // random cycles, device always ready
    for (int i = 0; i < 60; i++) begin
      int mo, em, s, a, r, h;
      bit wr;
      logic [4:0] ad;
      logic [15:0] wd;
      mo = $urandom_range(0, 7); em = (mo > 4) ? 4 : mo;
      s = $urandom_range(0, 6); a = $urandom_range(0, 6);
      r = $urandom_range(0, 6); h = $urandom_range(0, 6);
      setMode(em, s, a, r, h);
      cfgMinCycle = 16'($urandom_range(0, 20));
      cfgByteMode = 1'($urandom_range(0, 1));
      wr = 1'($urandom_range(0, 1)); ad = 5'($urandom); wd = 16'($urandom);
      din = 16'($urandom); ddIn = din;
      runCycle(wr, ad, wd, 3'(mo), 0, 0, 0);
      expTot = c1(s) + c1(a) + c1(r);
      if (em >= 3 && int'(cfgMinCycle) > expTot) expTot = int'(cfgMinCycle);
      expRec = expTot - c1(s) - c1(a);
      check(mSetup == c1(s), "R3", "setup cycles", mSetup, c1(s));
      check(mLow == c1(a), "R3", "strobe cycles", mLow, c1(a));
      check(mTot == expTot, "R7", "total cycles", mTot, expTot);
      check(mRec == expRec, "R3", "recovery cycles", mRec, expRec);
      check(mAddrBad == 0, "R2", "address mismatches", mAddrBad, 0);
      check(mDataBad == 0 && mSetupOe == 0, "R9", "data bus mismatches",
            mDataBad + mSetupOe, 0);
      check(mDones == 1 && !mErr, "R12", "done pulses", mDones, 1);
      check(curMode == 3'(em), "R12", "mode shown", int'(curMode), em);
      if (wr) check(mOe == ((h < expRec) ? h : expRec), "R9", "hold cycles", mOe,
                    (h < expRec) ? h : expRec);
      else check(mRd == narrow(cfgByteMode, din), "R8", "read data", int'(mRd),
                 int'(narrow(cfgByteMode, din)));
    end
    cfgMinCycle = '0;
    cfgByteMode = 1'b0;

    // R4 wait: sample at strobe cycle 2, ready returns after 6 low cycles
    cfgSamplePt = 8'd2; setMode(3, 2, 6, 2, 0);
    iordyLow();
    runCycle(0, 5'h0A, 16'h0, 3'd3, 6, 0, 0);
    expLow = 6 + 2 + 6 - 2;
    check(mLow == expLow, "R4", "extended strobe", mLow, expLow);
    check(!mErr, "R4", "err after normal wait", int'(mErr), 0);
    iordyHigh();

    // R5 low pulse that ends during setup
    cfgSamplePt = 8'd3; setMode(4, 6, 6, 2, 0);
    iordyLow();
    runCycle(0, 5'h11, 16'h0, 3'd4, 0, 1, 0);
    check(mLow == 6, "R5", "strobe after early release", mLow, 6);
    iordyHigh();

    // R6 slow mode ignores ready held low
    cfgSamplePt = 8'd1; setMode(2, 2, 5, 2, 0);
    iordyLow();
    runCycle(1, 5'h1F, 16'hBEEF, 3'd2, 0, 0, 0);
    check(mLow == 5, "R6", "slow mode strobe", mLow, 5);
    iordyHigh();

    // R10 timeout
    cfgSamplePt = 8'd2; cfgTimeout = 16'd5; setMode(3, 2, 6, 2, 0);
    ddIn = 16'h1234;
    iordyLow();
    runCycle(0, 5'h08, 16'h0, 3'd3, 0, 0, 0);
    check(mLow == 2 + 1 + 5, "R10", "timeout strobe", mLow, 8);
    check(mErr && mDones == 1, "R10", "err with done", int'(mErr), 1);
    iordyHigh();

    // R10 ready and timeout on the same edge: ready wins
    iordyLow();
    runCycle(0, 5'h08, 16'h0, 3'd3, 2 + 5 - 1, 0, 0);
    check(mLow == 6 + 2 + 6 - 2, "R10", "coincident strobe", mLow, 12);
    check(!mErr, "R10", "coincident err", int'(mErr), 0);
    iordyHigh();

    // R10 ready one cycle too late: timeout wins
    iordyLow();
    runCycle(0, 5'h08, 16'h0, 3'd3, 2 + 5, 0, 0);
    check(mErr, "R10", "late ready err", int'(mErr), 1);
    iordyHigh();
    cfgTimeout = 16'd100;

    // R7 floor in fast mode, not in slow mode
    cfgMinCycle = 16'd20; setMode(4, 1, 2, 1, 0); setMode(1, 1, 2, 1, 0);
    runCycle(0, 5'h09, 16'h0, 3'd4, 0, 0, 0);
    check(mTot == 20, "R7", "fast floor", mTot, 20);
    runCycle(0, 5'h09, 16'h0, 3'd1, 0, 0, 0);
    check(mTot == 4, "R7", "slow floor ignored", mTot, 4);
    cfgMinCycle = '0;

    // R3 zero counts act as one
    setMode(0, 0, 0, 0, 0);
    runCycle(0, 5'h03, 16'h0, 3'd0, 0, 0, 0);
    check(mSetup == 1 && mLow == 1 && mTot == 3, "R3", "zero counts total", mTot, 3);

    // R12 request while busy ignored
    setMode(0, 3, 3, 2, 0);
    runCycle(1, 5'h15, 16'h5AA5, 3'd0, 0, 0, 1);
    check(mAddrBad == 0 && mTot == 8, "R12", "busy request total", mTot, 8);
    check(mDones == 1, "R12", "done count with poke", mDones, 1);

    // R8 and R9 8-bit mode with hold window
    cfgByteMode = 1'b1; setMode(0, 2, 3, 5, 3); ddIn = 16'hA5C3;
    runCycle(0, 5'h0F, 16'h0, 3'd0, 0, 0, 0);
    check(mRd == 16'h00C3, "R8", "byte read", int'(mRd), 16'h00C3);
    runCycle(1, 5'h0F, 16'h7E81, 3'd0, 0, 0, 0);
    check(mDataBad == 0 && mOe == 3, "R9", "byte write hold", mOe, 3);
    check(dmackN === 1, "R11", "dmack level", int'(dmackN), 1);

    finishRun();
  end

endmodule